// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block gathers interrupt events for a peripheral interface device and drives one shared active-low interrupt request. There are seven sources: two timers, a shift register, and four handshake control lines, called CA1, CA2, CB1 and CB2. The timers and the shift register live elsewhere. Each of them delivers a one-cycle event pulse. The four control lines are raw asynchronous levels. Each line passes through a two-stage synchronizer and then an edge detector whose active edge is chosen by a peripheral control byte.

Every event sets a sticky flag. A separate enable mask decides which flags may pull the request line low. Software sees the flags and the enables through a small byte-wide register interface with a one-bit select. A write to either register takes effect at the clock edge. A read is combinational from the current state. Neighbouring logic can also clear single flags through per-source strobes, for example when a timer register is accessed.

All pins are plain control and status signals. The block has no streaming interface and no back-pressure.

Top module: `pifc_top`

## Requirements
- R1: Each source has a fixed flag bit: bit 6 timer 1, bit 5 timer 2, bit 4 CB1, bit 3 CB2, bit 2 shift register, bit 1 CA1, bit 0 CA2. An event on a source sets its flag at the next clock, whether or not that source is enabled.
- R2: A read of the flag register (`reg_addr`=0) returns the seven flags in bits 6..0. Bit 7 reads 1 exactly when some flag is set whose enable bit is also set; otherwise bit 7 reads 0.
- R3: A write to the enable register (`reg_addr`=1) with bit 7 = 1 sets the enable bits marked 1 in bits 6..0. With bit 7 = 0, the same write clears those bits. Enable bits marked 0 in the written byte keep their value.
- R4: A read of the enable register returns the seven enable bits in bits 6..0, with bit 7 always 0.
- R5: A write to the flag register clears every flag whose bit is 0 in bits 6..0 of the written byte. Bit 7 of the written byte is ignored, so writing 0x7F or 0xFF changes nothing.
- R6: `irq_n` is registered. It is 0 one clock after some flag and its enable bit are both 1, and it returns to 1 one clock after no such pair is left.
- R7: A 1 on `src_clr[i]` clears flag i at the next clock. Flag positions follow R1.
- R8: If an event and a clear (a strobe or a flag-register write) reach the same flag in the same cycle, the event wins and the flag ends up set.
- R9: After reset, all flags and enables are 0 and `irq_n` is 1.
- R10: `periph_ctl` selects the active edge of each control line: bit 0 for CA1, bit 2 for CA2, bit 4 for CB1 and bit 6 for CB2. A value of 1 selects the rising edge and 0 selects the falling edge. A matching edge on a line shows in its flag three clocks after the line changes; the opposite edge sets nothing.
- R11: CA2 is an output while `periph_ctl` bit 3 is 1, and CB2 is an output while bit 7 is 1. In output mode the line sets no flag.
- R12: The first synchronized sample after reset only records the line level. A line held high through reset produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 1 | Register select: 0 = flags, 1 = enables |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tmr1_evt | input | 1 | Timer 1 event pulse |
| tmr2_evt | input | 1 | Timer 2 event pulse |
| shift_evt | input | 1 | Shift register event pulse |
| src_clr | input | 7 | Per-source flag clear strobes, same bit positions as the flags |
| ctl_line | input | 4 | Raw control lines: [0] CA1, [1] CA2, [2] CB1, [3] CB2 |
| periph_ctl | input | 8 | Edge polarity and CA2/CB2 direction bits |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions check the following on every cycle:
- an event always lands in its flag;
- a flag never falls unless a clear was asked for;
- an enable write leaves its unmarked bits untouched;
- `irq_n` follows the flag-and-enable state with one clock of delay;
- CA2 and CB2 stay silent in output mode.

Some behaviours can only be shown by the bench's scenarios:
- the arithmetic of the set/clear enable writes and of the flag-register writes, which the bench sweeps over every byte;
- the exact three-clock latency and the polarity choice of each control line;
- the summary bit for each single source;
- the quiet first sample after a reset taken with the lines high.

// File: rtl/pifc_pkg.sv
package pifc_pkg;
  localparam int NSRC  = 7;
  localparam int NLINE = 4;

  // Flag bit positions, decoded by software
  localparam int B_T1  = 6;
  localparam int B_T2  = 5;
  localparam int B_CB1 = 4;
  localparam int B_CB2 = 3;
  localparam int B_SR  = 2;
  localparam int B_CA1 = 1;
  localparam int B_CA2 = 0;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic {
    SEL_FLAG = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/pifc_edge.sv
module pifc_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic rise_sel,
  input  logic gate_on,
  output logic evt
);
  localparam int FILL_W = SYNC_STAGES + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [FILL_W-1:0]      fill_q;
  logic                   lvl;
  logic                   primed;

  assign lvl    = sync_q[SYNC_STAGES-1];
  assign primed = fill_q[FILL_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      fill_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      prev_q <= lvl;
      fill_q <= {fill_q[FILL_W-2:0], 1'b1};
    end
  end

  // R10 R12: compare only once both samples hold real line levels
  assign evt = gate_on && primed && (lvl != prev_q) && (lvl == rise_sel);
endmodule

// File: rtl/pifc_regs.sv
module pifc_regs
  import pifc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  src_vec_t   src_evt,
  input  src_vec_t   src_clr,
  input  logic       flag_wr,
  input  src_vec_t   flag_wdata,
  input  logic       en_wr,
  input  logic [7:0] en_wdata,
  output src_vec_t   flags,
  output src_vec_t   enables,
  output logic       irq_n
);
  src_vec_t flags_q, en_q, clr_mask, flags_d, en_d;

  assign clr_mask = src_clr | (flag_wr ? ~flag_wdata : '0);
  assign flags_d  = (flags_q & ~clr_mask) | src_evt;   // R8: event wins

  always_comb begin
    en_d = en_q;
    if (en_wr) begin
      if (en_wdata[7]) en_d = en_q | en_wdata[NSRC-1:0];
      else             en_d = en_q & ~en_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_n   <= 1'b1;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_n   <= ~|(flags_q & en_q);
    end
  end

  assign flags   = flags_q;
  assign enables = en_q;

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_evt != '0) |=> ((flags_q & $past(src_evt)) == $past(src_evt)));

  // R7
  no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags_q) & ~flags_q) & ~$past(clr_mask)) == '0));

  // R3
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (((en_q ^ $past(en_q)) & ~$past(en_wdata[NSRC-1:0])) == '0));

  // R6
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & en_q) == '0) |=> irq_n);

  // R6
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & en_q) != '0) |=> !irq_n);
endmodule

// File: rtl/pifc_top.sv
module pifc_top
  import pifc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tmr1_evt,
  input  logic       tmr2_evt,
  input  logic       shift_evt,
  input  logic [6:0] src_clr,
  input  logic [3:0] ctl_line,
  input  logic [7:0] periph_ctl,
  output logic       irq_n
);
  logic [NLINE-1:0] rise_v, gate_v, line_evt;
  src_vec_t         src_evt, flags, enables;
  logic             sel_en;

  // line order: CA1, CA2, CB1, CB2
  assign rise_v = {periph_ctl[6], periph_ctl[4], periph_ctl[2], periph_ctl[0]};
  assign gate_v = {~periph_ctl[7], 1'b1, ~periph_ctl[3], 1'b1};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    pifc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .line_in(ctl_line[g]),
      .rise_sel(rise_v[g]), .gate_on(gate_v[g]), .evt(line_evt[g])
    );
  end

  always_comb begin
    src_evt        = '0;
    src_evt[B_T1]  = tmr1_evt;
    src_evt[B_T2]  = tmr2_evt;
    src_evt[B_SR]  = shift_evt;
    src_evt[B_CA1] = line_evt[0];
    src_evt[B_CA2] = line_evt[1];
    src_evt[B_CB1] = line_evt[2];
    src_evt[B_CB2] = line_evt[3];
  end

  assign sel_en = (reg_sel_e'(reg_addr) == SEL_EN);

  pifc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .src_evt(src_evt), .src_clr(src_clr),
    .flag_wr(reg_wr && !sel_en), .flag_wdata(reg_wdata[NSRC-1:0]),
    .en_wr(reg_wr && sel_en), .en_wdata(reg_wdata),
    .flags(flags), .enables(enables), .irq_n(irq_n)
  );

  // R2 R4
  assign reg_rdata = sel_en ? {1'b0, enables} : {|(flags & enables), flags};

  // R11
  ca2_out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ctl[3] |-> !line_evt[1]);

  // R11
  cb2_out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ctl[7] |-> !line_evt[3]);
endmodule

// File: tb/pifc_top_bench.sv
module pifc_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tmr1_evt = 1'b0, tmr2_evt = 1'b0, shift_evt = 1'b0;
  logic [6:0] src_clr = '0;
  logic [3:0] ctl_line = '0;
  logic [7:0] periph_ctl = '0;
  logic       irq_n;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pifc_top u_pifc_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr1_evt(tmr1_evt),
    .tmr2_evt(tmr2_evt), .shift_evt(shift_evt), .src_clr(src_clr),
    .ctl_line(ctl_line), .periph_ctl(periph_ctl), .irq_n(irq_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // sets all seven flags; needs periph_ctl = 8'h55 and lines low
  task automatic set_all();
    tmr1_evt = 1'b1; tmr2_evt = 1'b1; shift_evt = 1'b1; ctl_line = 4'hF;
    tick(1);
    tmr1_evt = 1'b0; tmr2_evt = 1'b0; shift_evt = 1'b0;
    tick(3);
    ctl_line = 4'h0;
    tick(4);
  endtask

  function automatic int line_bit(input int l);
    case (l)
      0: return 1;
      1: return 0;
      2: return 4;
      default: return 3;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [6:0] exp_en;

    tick(2);
    rst_n = 1'b1;
    tick(1);

    // R9: reset state
    rd(1'b0, d); chk("R9 flags", d, 8'h00);
    rd(1'b1, d); chk("R9 enables", d, 8'h00);
    chk("R9 irq_n", {7'd0, irq_n}, 8'h01);

    // R3 R4: every enable write byte
    exp_en = '0;
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, v[7:0]);
      if (v[7]) exp_en = exp_en | v[6:0];
      else      exp_en = exp_en & ~v[6:0];
      rd(1'b1, d);
      chk("R3 R4 enable rw", d, {1'b0, exp_en});
    end
    wr(1'b1, 8'h7F);

    // R1 R6: events set flags with enables off, irq stays high
    tmr1_evt = 1'b1; tick(1); tmr1_evt = 1'b0;
    rd(1'b0, d); chk("R1 timer1 bit6", d, 8'h40);
    tmr2_evt = 1'b1; tick(1); tmr2_evt = 1'b0;
    rd(1'b0, d); chk("R1 timer2 bit5", d, 8'h60);
    shift_evt = 1'b1; tick(1); shift_evt = 1'b0;
    rd(1'b0, d); chk("R1 R2 shift bit2, summary 0", d, 8'h64);
    tick(1);
    chk("R6 irq_n with no enables", {7'd0, irq_n}, 8'h01);

    // R10: polarity sweep over every line
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 2; p++) begin
        periph_ctl = p[0] ? (8'h01 << (2 * l)) : 8'h00;
        wr(1'b0, 8'h00);
        ctl_line[l] = 1'b1;
        tick(2);
        rd(1'b0, d); chk("R10 rise not yet", d, 8'h00);
        tick(1);
        rd(1'b0, d); chk("R10 rising edge", d, p[0] ? (8'h01 << line_bit(l)) : 8'h00);
        wr(1'b0, 8'h00);
        ctl_line[l] = 1'b0;
        tick(2);
        rd(1'b0, d); chk("R10 fall not yet", d, 8'h00);
        tick(1);
        rd(1'b0, d); chk("R10 falling edge", d, p[0] ? 8'h00 : (8'h01 << line_bit(l)));
      end
    end

    // R11: CA2 and CB2 in output mode set nothing
    periph_ctl = 8'hCC;
    wr(1'b0, 8'h00);
    ctl_line = 4'b1010;
    tick(4);
    rd(1'b0, d); chk("R11 output mode rising", d, 8'h00);
    ctl_line = 4'b0000;
    tick(4);
    rd(1'b0, d); chk("R11 output mode falling", d, 8'h00);

    // R5: every flag write byte
    periph_ctl = 8'h55;
    for (int v = 0; v < 256; v++) begin
      set_all();
      wr(1'b0, v[7:0]);
      rd(1'b0, d);
      chk("R5 flag write clear", d, {1'b0, v[6:0]});
    end

    // R2 R6: summary bit and irq timing per source
    for (int i = 0; i < 7; i++) begin
      set_all();
      wr(1'b0, 8'h01 << i);
      wr(1'b1, 8'h80 | (8'h01 << i));
      chk("R6 irq_n not yet", {7'd0, irq_n}, 8'h01);
      rd(1'b0, d); chk("R2 summary on", d, 8'h80 | (8'h01 << i));
      tick(1);
      chk("R6 irq_n asserted", {7'd0, irq_n}, 8'h00);
      wr(1'b1, 8'h01 << i);
      wr(1'b1, 8'h80 | (8'h01 << ((i + 1) % 7)));
      rd(1'b0, d); chk("R2 summary off", d, 8'h01 << i);
      tick(1);
      chk("R6 irq_n released", {7'd0, irq_n}, 8'h01);
      wr(1'b1, 8'h7F);
    end

    // R7: per-source clear strobes
    for (int i = 0; i < 7; i++) begin
      set_all();
      src_clr = 7'h01 << i;
      tick(1);
      src_clr = '0;
      rd(1'b0, d); chk("R7 strobe clear", d, {1'b0, 7'h7F & ~(7'h01 << i)});
    end

    // R8: event wins against strobe and against flag write
    wr(1'b0, 8'h00);
    tmr2_evt = 1'b1; src_clr = 7'h20;
    tick(1);
    tmr2_evt = 1'b0; src_clr = '0;
    rd(1'b0, d); chk("R8 event vs strobe", d, 8'h20);
    reg_addr = 1'b0; reg_wdata = 8'h00; reg_wr = 1'b1; tmr1_evt = 1'b1;
    tick(1);
    reg_wr = 1'b0; tmr1_evt = 1'b0;
    rd(1'b0, d); chk("R8 event vs flag write", d, 8'h40);

    // R9 R12: reset with state set and lines high, rising polarity
    wr(1'b1, 8'hFF);
    ctl_line = 4'hF;
    tick(2);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
    chk("R9 irq_n after reset", {7'd0, irq_n}, 8'h01);
    rd(1'b1, d); chk("R9 enables after reset", d, 8'h00);
    tick(6);
    rd(1'b0, d); chk("R12 no edge from first sample", d, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule